// File: doc/BRIEF.md
# Non-Display Gate Scan Controller

This block chooses, one frame at a time, how the gate lines that fall outside the visible window of a TFT panel are treated. The same treatment covers every blank region and both porch periods. A 16-bit control word holds two fields: a scan-mode selector and an interval code. A frame-start strobe marks frame boundaries. A per-line flag tells the block whether the current line period is a blank or porch period. Inside the visible window the gates are always scanned.

In the blank and porch periods there are three treatments. In normal mode the gates are scanned on every frame, and the drive polarity alternates on every frame. In fixed-low mode the gates are held at the low gate level, the timing output is driven to ground, and the polarity is frozen. In interval mode the gates are scanned on only one frame in every 2c+1 frames, where c is the interval code, and the polarity flips only on the frames that are scanned. Any reserved setting falls back to the fixed-low treatment.

A new control word is held in a pending slot and is adopted only at the next frame-start strobe, so no frame is ever driven under two settings. Three outputs leave the block: a combinational gate-scan enable for the current line, a registered copy of that enable used as the display-timing level, and the drive-polarity bit.

Top module: `ndscan_gate_ctrl`

## Requirements
- R1: While `rst` is high on a clock edge, the active setting becomes normal mode with interval code 0, the interval phase becomes 0, `drive_pol` becomes 0 and `disp_tmg` becomes 0.
- R2: The scan-mode field is word bits [5:4] and the interval code is bits [3:0]. Every other bit of `cfg_wr_data` has no effect on any output.
- R3: A write is held as pending and becomes active at the clock edge that samples the next `frame_start`. A write in the same cycle as `frame_start` is applied at that strobe. When several writes come before one strobe, the last one is the one applied.
- R4: When `in_porch` is 0, `gate_scan_en` is 1 whatever the setting.
- R5: In mode 0 (normal), `gate_scan_en` is 1 during porch lines, and `drive_pol` inverts at every frame-start strobe.
- R6: In mode 1 (fixed low), `gate_scan_en` is 0 during porch lines, and `drive_pol` keeps its value across frame-start strobes.
- R7: In mode 2 with code c ≥ 1, the frames form a cycle of 2c+1. The first frame after the setting is entered, or after the code changes, is a scan frame (phase 0). During porch lines `gate_scan_en` is 1 only on scan frames.
- R8: In mode 2 with code c ≥ 1, `drive_pol` inverts at the strobe that opens each scan frame and at no other strobe.
- R9: The reserved settings, mode 3 (any code) and mode 2 with code 0, behave exactly like mode 1.
- R10: `disp_tmg` equals the value `gate_scan_en` had one clock cycle earlier.
- R11: `drive_pol` changes only at a clock edge that samples `frame_start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 16 | Control word: mode in [5:4], interval code in [3:0] |
| frame_start | input | 1 | One-cycle pulse that opens a frame |
| in_porch | input | 1 | High while the current line is a blank or porch period |
| gate_scan_en | output | 1 | Gates are scanned on the current line |
| disp_tmg | output | 1 | Display-timing level: `gate_scan_en` delayed one cycle |
| drive_pol | output | 1 | Alternating drive polarity |

## Verification
`gate_scan_en` is a combinational function of the state that the most recent edge left behind and of the current `in_porch`. It is therefore due in the same cycle in which `in_porch` is driven. A strobe or a write takes effect one edge later. `disp_tmg` lags `gate_scan_en` by one further edge. The bench drives its inputs just after each rising edge and, in the same step, steps an independent frame model over the inputs that the edge has just consumed. It then queues the expected triple for that cycle, and the monitor compares that triple at the following falling edge. Because of this, every check lands in the one cycle whose outcome the model has already settled.

// File: rtl/ndscan_pkg.sv
package ndscan_pkg;

    localparam int ICODE_W  = 4;
    localparam int MODE_LSB = ICODE_W;
    localparam int USED_W   = MODE_LSB + 2;
    localparam int PHASE_W  = ICODE_W + 1;

    typedef enum logic [1:0] {
        SM_NORMAL   = 2'd0,
        SM_FIXLOW   = 2'd1,
        SM_INTERVAL = 2'd2,
        SM_OFF      = 2'd3
    } scan_mode_e;

    typedef struct packed {
        scan_mode_e           mode;
        logic [ICODE_W-1:0]   icode;
    } scan_cfg_t;

    typedef enum logic [1:0] {
        DRV_ALL    = 2'd0,
        DRV_LOW    = 2'd1,
        DRV_SPARSE = 2'd2
    } drive_cls_e;

    localparam scan_cfg_t CFG_RESET = '{mode: SM_NORMAL, icode: '0};

    function automatic scan_cfg_t decode_word(input logic [USED_W-1:0] lo);
        scan_cfg_t c;
        c.mode  = scan_mode_e'(lo[MODE_LSB +: 2]);
        c.icode = lo[ICODE_W-1:0];
        return c;
    endfunction

    // Reserved settings collapse onto the fixed-low treatment.
    function automatic drive_cls_e classify(input scan_cfg_t c);
        drive_cls_e k;
        case (c.mode)
            SM_NORMAL:   k = DRV_ALL;
            SM_INTERVAL: k = (c.icode != '0) ? DRV_SPARSE : DRV_LOW;
            default:     k = DRV_LOW;
        endcase
        return k;
    endfunction

    // Highest phase of a 2c+1 frame cycle is 2c.
    function automatic logic [PHASE_W-1:0] top_phase(input logic [ICODE_W-1:0] code);
        return {code, 1'b0};
    endfunction

endpackage

// File: rtl/ndscan_cfg_hold.sv
module ndscan_cfg_hold
    import ndscan_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              frame_start,
    output scan_cfg_t         act_cfg,
    output scan_cfg_t         nxt_cfg
);

    scan_cfg_t pend_cfg;
    scan_cfg_t wr_cfg;
    logic      unused_hi;

    assign wr_cfg    = decode_word(wr_data[USED_W-1:0]);
    assign unused_hi = ^wr_data[WORD_W-1:USED_W];

    // Setting that a strobe in this cycle would adopt.
    assign nxt_cfg = wr_en ? wr_cfg : pend_cfg;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cfg <= CFG_RESET;
            act_cfg  <= CFG_RESET;
        end else begin
            if (wr_en)
                pend_cfg <= wr_cfg;
            if (frame_start)
                act_cfg <= nxt_cfg;
        end
    end

endmodule

// File: rtl/ndscan_frame_seq.sv
module ndscan_frame_seq
    import ndscan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_start,
    input  scan_cfg_t          act_cfg,
    input  scan_cfg_t          nxt_cfg,
    output logic [PHASE_W-1:0] phase,
    output logic               drive_pol
);

    drive_cls_e         act_cls;
    drive_cls_e         nxt_cls;
    logic               same_run;
    logic [PHASE_W-1:0] adv;
    logic [PHASE_W-1:0] phase_n;
    logic               flip;

    assign act_cls  = classify(act_cfg);
    assign nxt_cls  = classify(nxt_cfg);
    assign same_run = (act_cls == DRV_SPARSE) && (act_cfg.icode == nxt_cfg.icode);
    assign adv      = (phase == top_phase(nxt_cfg.icode)) ? '0 : phase + 1'b1;

    always_comb begin
        phase_n = '0;
        flip    = 1'b0;
        case (nxt_cls)
            DRV_SPARSE: begin
                phase_n = same_run ? adv : '0;
                flip    = (phase_n == '0);
            end
            DRV_ALL: flip = 1'b1;
            default: flip = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= '0;
            drive_pol <= 1'b0;
        end else if (frame_start) begin
            phase     <= phase_n;
            drive_pol <= drive_pol ^ flip;
        end
    end

endmodule

// File: rtl/ndscan_gate_ctrl.sv
module ndscan_gate_ctrl
    import ndscan_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [WORD_W-1:0] cfg_wr_data,
    input  logic              frame_start,
    input  logic              in_porch,
    output logic              gate_scan_en,
    output logic              disp_tmg,
    output logic              drive_pol
);

    scan_cfg_t          act_cfg;
    scan_cfg_t          nxt_cfg;
    logic [PHASE_W-1:0] phase;
    drive_cls_e         cls;
    logic               scan_frame;

    ndscan_cfg_hold #(.WORD_W(WORD_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_wr_en),
        .wr_data     (cfg_wr_data),
        .frame_start (frame_start),
        .act_cfg     (act_cfg),
        .nxt_cfg     (nxt_cfg)
    );

    ndscan_frame_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .act_cfg     (act_cfg),
        .nxt_cfg     (nxt_cfg),
        .phase       (phase),
        .drive_pol   (drive_pol)
    );

    assign cls          = classify(act_cfg);
    assign scan_frame   = (cls == DRV_ALL) || ((cls == DRV_SPARSE) && (phase == '0));
    assign gate_scan_en = !in_porch || scan_frame;

    always_ff @(posedge clk) begin
        if (rst)
            disp_tmg <= 1'b0;
        else
            disp_tmg <= gate_scan_en;
    end

endmodule

// File: rtl/ndscan_gate_chk.sv
module ndscan_gate_chk
    import ndscan_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               frame_start,
    input logic               in_porch,
    input logic               gate_scan_en,
    input logic               disp_tmg,
    input logic               drive_pol,
    input scan_cfg_t          act_cfg,
    input logic [PHASE_W-1:0] phase
);

    assert_visible_scanned_R4: assert property (@(posedge clk) disable iff (rst)
        !in_porch |-> gate_scan_en);

    assert_tmg_lag_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (disp_tmg == $past(gate_scan_en)));

    assert_pol_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(drive_pol));

    assert_cfg_deferred_R3: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(act_cfg));

    assert_phase_bound_R7: assert property (@(posedge clk) disable iff (rst)
        (classify(act_cfg) == DRV_SPARSE) |-> (phase <= top_phase(act_cfg.icode)));

    assert_low_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        (in_porch && classify(act_cfg) == DRV_LOW) |-> !gate_scan_en);

endmodule

bind ndscan_gate_ctrl ndscan_gate_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .in_porch     (in_porch),
    .gate_scan_en (gate_scan_en),
    .disp_tmg     (disp_tmg),
    .drive_pol    (drive_pol),
    .act_cfg      (act_cfg),
    .phase        (phase)
);

// File: tb/ndscan_gate_ctrl_bench.sv
`timescale 1ns/1ps
module ndscan_gate_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [15:0] cfg_wr_data = '0;
    logic        frame_start = 1'b0;
    logic        in_porch = 1'b1;
    logic        gate_scan_en;
    logic        disp_tmg;
    logic        drive_pol;

    always #10 clk = ~clk;

    ndscan_gate_ctrl u_ndscan_gate_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_data  (cfg_wr_data),
        .frame_start  (frame_start),
        .in_porch     (in_porch),
        .gate_scan_en (gate_scan_en),
        .disp_tmg     (disp_tmg),
        .drive_pol    (drive_pol)
    );

    typedef struct {
        string req;
        bit    scan;
        bit    tmg;
        bit    pol;
        bit    chk;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 0;

    // Reference frame model
    int    m_mode = 0, m_code = 0, p_mode = 0, p_code = 0, m_phase = 0;
    bit    m_pol = 0, m_tmg = 0, prev_scan = 0;
    bit    l_rst = 1, l_fs = 0, l_we = 0;
    logic [15:0] l_wd = '0;

    task automatic cyc(input bit r, input bit fs, input bit we, input logic [15:0] wd,
                       input bit porch, input bit chk, input string req);
        bit was_run;
        bit exp_scan;
        item_t it;
        @(posedge clk);
        #1;
        if (l_rst) begin
            m_mode = 0; m_code = 0; p_mode = 0; p_code = 0;
            m_phase = 0; m_pol = 0; m_tmg = 0;
        end else begin
            m_tmg = prev_scan;
            if (l_we) begin
                p_mode = int'((l_wd >> 4) & 16'h3);
                p_code = int'(l_wd & 16'hF);
            end
            if (l_fs) begin
                was_run = (m_mode == 2) && (m_code != 0);
                if (p_mode == 2 && p_code != 0) begin
                    if (was_run && m_code == p_code)
                        m_phase = (m_phase + 1) % (2 * p_code + 1);
                    else
                        m_phase = 0;
                    if (m_phase == 0) m_pol = !m_pol;
                end else begin
                    m_phase = 0;
                    if (p_mode == 0) m_pol = !m_pol;
                end
                m_mode = p_mode;
                m_code = p_code;
            end
        end
        rst = r; frame_start = fs; cfg_wr_en = we; cfg_wr_data = wd; in_porch = porch;
        exp_scan = !porch || (m_mode == 0) || (m_mode == 2 && m_code != 0 && m_phase == 0);
        it.req = req; it.scan = exp_scan; it.tmg = m_tmg; it.pol = m_pol; it.chk = chk;
        q.push_back(it);
        prev_scan = exp_scan;
        l_rst = r; l_fs = fs; l_we = we; l_wd = wd;
    endtask

    task automatic frame(input string req);
        cyc(0, 1, 0, 16'h0, 1, 0, "");
        cyc(0, 0, 0, 16'h0, 1, 1, req);
        cyc(0, 0, 0, 16'h0, 0, 1, {req, " R4"});
    endtask

    task automatic wr(input logic [15:0] wd);
        cyc(0, 0, 1, wd, 1, 1, "R3");
    endtask

    // Monitor: pops the expectation for each cycle at the falling edge
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                if (it.chk) begin
                    n_chk++;
                    if (gate_scan_en !== it.scan || disp_tmg !== it.tmg || drive_pol !== it.pol) begin
                        n_fail++;
                        $display("FAIL %s (disp_tmg per R10): scan=%0b exp %0b, tmg=%0b exp %0b, pol=%0b exp %0b at %0t",
                                 it.req, gate_scan_en, it.scan, disp_tmg, it.tmg, drive_pol, it.pol, $time);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cyc(1, 0, 0, 16'h0, 1, 0, "");
        cyc(1, 0, 0, 16'h0, 1, 0, "");
        cyc(0, 0, 0, 16'h0, 1, 1, "R1");
        cyc(0, 0, 0, 16'h0, 0, 1, "R1");
        // normal mode: polarity flips every frame
        for (int i = 0; i < 3; i++) frame("R5");
        // fixed low, deferred to the strobe
        wr(16'h0010);
        cyc(0, 0, 0, 16'h0, 1, 1, "R3");
        for (int i = 0; i < 2; i++) frame("R6");
        // interval code 1: 3-frame cycle
        wr(16'h0021);
        for (int i = 0; i < 7; i++) frame("R7 R8");
        // interval code 15: 31-frame cycle, code change restarts phase
        wr(16'h002F);
        for (int i = 0; i < 33; i++) frame("R7 R8");
        // reserved settings
        wr(16'h0020);
        for (int i = 0; i < 2; i++) frame("R9");
        wr(16'h0035);
        for (int i = 0; i < 2; i++) frame("R9");
        // reserved and partial-source bits set, must act as mode 2 code 1
        wr(16'hFFE1);
        for (int i = 0; i < 4; i++) frame("R2");
        // write in the strobe cycle applies at that strobe
        cyc(0, 1, 1, 16'h0000, 1, 0, "");
        cyc(0, 0, 0, 16'h0, 1, 1, "R3");
        // last of several writes wins
        wr(16'h0010);
        wr(16'h0021);
        for (int i = 0; i < 3; i++) frame("R3");
        // reset mid-run
        cyc(1, 0, 0, 16'h0, 1, 0, "");
        cyc(0, 0, 0, 16'h0, 1, 1, "R1");
        cyc(0, 0, 0, 16'h0, 1, 0, "");
        cyc(0, 0, 0, 16'h0, 1, 0, "");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule